// File: doc/BRIEF.md
# DMA Transfer-Request Decoder with Per-Channel Queues

This block stands between an external requesting device and a four-channel DMA controller. A device raises a one-cycle strobe. It can supply a request word with it, made of a two-bit channel field, a two-bit mode field and a three-bit size field. It can also give the strobe alone, or give the strobe together with its bus-request line. The block turns each strobe into one action: a channel-0 handshake request, an end-of-transfer command that drops the channel-0 enable, a clear of all request queues, or a request for channel 1, 2 or 3.

Requests for channels 1 to 3 wait in small per-channel counting queues. Each queue is offered to the controller through a valid/ready pair and gives up one entry per handshake. A bare strobe repeats the channel that was named most recently. The block also holds the channel-0 transfer-end flag and the channel-0 enable. If a bare strobe for channel 0 arrives while the end flag is set, the block locks up. It unlocks only after software has read the flag as set and then writes a clear.

Top module: `dreq_decoder`

## Requirements
- R1: With strobe high, word_valid high, bus request low, channel field 0, mode field 0 and size field neither 5 nor 6, `ch0_req` is high for one cycle after the next clock edge.
- R2: A strobed word with channel field 0, mode field not 0 and size field 7 clears `ch0_de` at the next edge, and this wins over `sw_de_set` in the same cycle. `sw_de_set` alone sets `ch0_de`.
- R3: A strobed word with channel field 0, size field 6 and mode field not 2 empties every queue: all `q_valid` bits are low after the edge.
- R4: A strobed word with a non-zero channel field N adds one entry to queue N, whatever the mode and size fields hold. `q_valid` bit N-1 is high while that queue holds entries. An entry is removed on each edge where that bit and `q_ready` bit N-1 are both high.
- R5: Each queue holds at most DEPTH entries (4 by default). A request that arrives for a full queue is discarded.
- R6: A channel-0 request that arrives while `ch0_busy` is high produces no `ch0_req`.
- R7: A strobe with word_valid low and bus request low repeats the last channel named by a decoded request word or by a direct request. When no channel has been named since reset, it is ignored.
- R8: A bare strobe that repeats channel 0 while `te_flag` is 1 sets `frozen`. While frozen, every strobe is ignored. `frozen` and `te_flag` fall only on an `sw_te_clear` that follows an `sw_te_read` made while `te_flag` was 1.
- R9: A strobe together with `breq_in` adds one entry to the channel-2 queue if it has room. `bus_avail` stays low on the next cycle. Otherwise `bus_avail` follows `breq_in` one cycle later.
- R10: `te_set` sets `te_flag` at the next edge and wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_strobe | input | 1 | Request strobe |
| word_valid | input | 1 | A request word accompanies the strobe |
| req_id | input | 2 | Channel field of the request word |
| req_md | input | 2 | Mode field of the request word |
| req_sz | input | 3 | Size field of the request word |
| breq_in | input | 1 | Device bus-request line |
| ch0_busy | input | 1 | Channel-0 bus cycle in progress |
| te_set | input | 1 | Channel-0 transfer has ended |
| sw_te_read | input | 1 | Software reads the end flag |
| sw_te_clear | input | 1 | Software writes the end flag to 0 |
| sw_de_set | input | 1 | Software sets the channel-0 enable |
| ch0_req | output | 1 | Channel-0 transfer request pulse |
| ch0_de | output | 1 | Channel-0 enable |
| te_flag | output | 1 | Channel-0 transfer-end flag |
| frozen | output | 1 | Block is locked up |
| bus_avail | output | 1 | Bus-available indication |
| q_valid | output | 3 | Queue non-empty, bit i for channel i+1 |
| q_ready | input | 3 | Controller takes one entry, bit i for channel i+1 |

## Verification
A strobe that lands on a queue can fall in the same cycle as a controller handshake that pops that queue. The end-of-transfer command can likewise meet a software enable write. Random stimulus with a fixed seed drives strobes, request fields, `q_ready`, `sw_de_set` and the flag controls all at once, so pushes meet pops on full, nearly empty and empty queues, and end commands meet enable writes. Each cycle is judged against a bench model of queue counts and flags: a push onto a full queue is lost even when a pop happens at that edge, and the end command beats the enable write.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_BARE, K_DIRECT, K_CH0, K_END, K_CLEAR, K_CHN
  } req_kind_t;

  // Classify one strobe; direct mode (strobe with bus request) comes first.
  function automatic req_kind_t classify(input logic strobe, input logic has_word,
                                         input logic breq, input logic [1:0] id,
                                         input logic [1:0] md, input logic [2:0] sz);
    if (!strobe)                                return K_NONE;
    if (breq)                                   return K_DIRECT;
    if (!has_word)                              return K_BARE;
    if (id != 2'd0)                             return K_CHN;
    if (md == 2'd0 && sz != 3'd5 && sz != 3'd6) return K_CH0;
    if (md != 2'd0 && sz == 3'd7)               return K_END;
    if (sz == 3'd6 && md != 2'd2)               return K_CLEAR;
    return K_NONE;
  endfunction

  // Queue occupancy step: clear first, a push to a full queue is lost.
  function automatic int unsigned occ_next(input int unsigned cnt, input int unsigned depth,
                                           input logic clr, input logic push, input logic pop);
    int unsigned n;
    if (clr) return 0;
    n = cnt;
    if (pop && cnt != 0) n = n - 1;
    if (push && cnt < depth) n = n + 1;
    return n;
  endfunction
endpackage

// File: rtl/dreq_queue.sv
module dreq_queue #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic ready,
  output logic valid
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  logic [CW-1:0] cnt;
  logic          pop;

  assign pop   = ready && (cnt != '0);
  assign valid = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CW'(dreq_pkg::occ_next(int'(cnt), DEPTH, clr, push, pop));
  end
endmodule

// File: rtl/dreq_ch0_ctl.sv
module dreq_ch0_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic te_set,
  input  logic sw_te_read,
  input  logic sw_te_clear,
  input  logic sw_de_set,
  input  logic end_cmd,
  input  logic freeze_evt,
  output logic te_flag,
  output logic frozen,
  output logic ch0_de,
  output logic unfreeze
);
  logic rd_seen;

  assign unfreeze = sw_te_clear && rd_seen && !te_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_flag <= 1'b0;
      rd_seen <= 1'b0;
      frozen  <= 1'b0;
      ch0_de  <= 1'b0;
    end else begin
      if (te_set)        te_flag <= 1'b1;
      else if (unfreeze) te_flag <= 1'b0;

      if (unfreeze)                     rd_seen <= 1'b0;
      else if (sw_te_read && te_flag)   rd_seen <= 1'b1;

      if (unfreeze)        frozen <= 1'b0;
      else if (freeze_evt) frozen <= 1'b1;

      if (end_cmd)        ch0_de <= 1'b0;
      else if (sw_de_set) ch0_de <= 1'b1;
    end
  end
endmodule

// File: rtl/dreq_decoder.sv
module dreq_decoder #(
  parameter int unsigned NCH   = 3,
  parameter int unsigned DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_strobe,
  input  logic           word_valid,
  input  logic [1:0]     req_id,
  input  logic [1:0]     req_md,
  input  logic [2:0]     req_sz,
  input  logic           breq_in,
  input  logic           ch0_busy,
  input  logic           te_set,
  input  logic           sw_te_read,
  input  logic           sw_te_clear,
  input  logic           sw_de_set,
  output logic           ch0_req,
  output logic           ch0_de,
  output logic           te_flag,
  output logic           frozen,
  output logic           bus_avail,
  output logic [NCH-1:0] q_valid,
  input  logic [NCH-1:0] q_ready
);
  import dreq_pkg::*;
  localparam int unsigned DIRECT_CH = 2;

  req_kind_t      kind;
  logic           accept;
  logic [1:0]     last_ch;
  logic           last_v;
  logic [1:0]     tgt_ch;
  logic           tgt_push;
  logic [NCH-1:0] push_vec;
  logic           clr_q, end_cmd, ch0_hit, freeze_evt, bare_fresh, unfreeze;

  assign kind   = classify(req_strobe, word_valid, breq_in, req_id, req_md, req_sz);
  assign accept = !frozen;

  always_comb begin
    tgt_ch     = 2'd0;
    tgt_push   = 1'b0;
    ch0_hit    = 1'b0;
    freeze_evt = 1'b0;
    unique case (kind)
      K_DIRECT: begin tgt_ch = 2'(DIRECT_CH); tgt_push = 1'b1; end
      K_CHN:    begin tgt_ch = req_id;        tgt_push = 1'b1; end
      K_CH0:    ch0_hit = 1'b1;
      K_BARE: if (last_v) begin
        if (last_ch != 2'd0) begin tgt_ch = last_ch; tgt_push = 1'b1; end
        else if (te_flag)  freeze_evt = accept;
        else               ch0_hit = 1'b1;
      end
      default: ;
    endcase
  end

  assign clr_q      = accept && (kind == K_CLEAR);
  assign end_cmd    = accept && (kind == K_END);
  assign bare_fresh = (kind == K_BARE) && !last_v;

  for (genvar i = 0; i < NCH; i++) begin : g_q
    assign push_vec[i] = accept && tgt_push && (tgt_ch == 2'(i + 1));
    dreq_queue #(.DEPTH(DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .clr(clr_q), .push(push_vec[i]),
      .ready(q_ready[i]), .valid(q_valid[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ch   <= 2'd0;
      last_v    <= 1'b0;
      ch0_req   <= 1'b0;
      bus_avail <= 1'b0;
    end else begin
      ch0_req   <= accept && ch0_hit && !ch0_busy;
      bus_avail <= breq_in && !req_strobe;
      if (accept && (kind == K_CHN || kind == K_DIRECT || kind == K_CH0)) begin
        last_v  <= 1'b1;
        last_ch <= (kind == K_CH0) ? 2'd0 : tgt_ch;
      end
    end
  end

  dreq_ch0_ctl u_ch0 (
    .clk(clk), .rst_n(rst_n), .te_set(te_set), .sw_te_read(sw_te_read),
    .sw_te_clear(sw_te_clear), .sw_de_set(sw_de_set), .end_cmd(end_cmd),
    .freeze_evt(freeze_evt), .te_flag(te_flag), .frozen(frozen),
    .ch0_de(ch0_de), .unfreeze(unfreeze)
  );
endmodule

// File: rtl/dreq_checks.sv
module dreq_checks #(
  parameter int unsigned NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_strobe,
  input logic           breq_in,
  input logic           ch0_busy,
  input logic           te_set,
  input logic           frozen,
  input logic           ch0_req,
  input logic           ch0_de,
  input logic           te_flag,
  input logic           bus_avail,
  input logic [NCH-1:0] q_valid,
  input logic [NCH-1:0] q_ready,
  input logic           clr_q,
  input logic           end_cmd,
  input logic           bare_fresh
);
  assert_end_drops_de_R2: assert property (@(posedge clk) disable iff (!rst_n)
    end_cmd |=> !ch0_de);
  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (q_valid == '0));
  assert_valid_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_q |=> (($past(q_valid) & ~$past(q_ready) & ~q_valid) == '0));
  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && !breq_in && ch0_busy) |=> !ch0_req);
  assert_fresh_bare_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bare_fresh |=> !ch0_req);
  assert_frozen_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> !ch0_req);
  assert_direct_no_bavail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && breq_in) |=> !bus_avail);
  assert_te_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
    te_set |=> te_flag);
endmodule

bind dreq_decoder dreq_checks #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe), .breq_in(breq_in),
  .ch0_busy(ch0_busy), .te_set(te_set), .frozen(frozen), .ch0_req(ch0_req),
  .ch0_de(ch0_de), .te_flag(te_flag), .bus_avail(bus_avail), .q_valid(q_valid),
  .q_ready(q_ready), .clr_q(clr_q), .end_cmd(end_cmd), .bare_fresh(bare_fresh)
);

// File: tb/sim_dreq_decoder.sv
module sim_dreq_decoder;
  localparam int NCH = 3;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe, wv, breq, busy, tes, trd, tclr, deset;
  logic [1:0] id, md;
  logic [2:0] sz;
  logic [NCH-1:0] rdy;
  logic ch0_req, ch0_de, te_flag, frozen, bavail;
  logic [NCH-1:0] qv;

  int checks = 0, errors = 0;
  int mcnt[NCH];
  int mlast;
  bit mlastv, mte, mrd, mfroz, mde, mreq, mbav;

  always #10 clk = ~clk;

  dreq_decoder #(.NCH(NCH), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_strobe(strobe), .word_valid(wv), .req_id(id),
    .req_md(md), .req_sz(sz), .breq_in(breq), .ch0_busy(busy), .te_set(tes),
    .sw_te_read(trd), .sw_te_clear(tclr), .sw_de_set(deset), .ch0_req(ch0_req),
    .ch0_de(ch0_de), .te_flag(te_flag), .frozen(frozen), .bus_avail(bavail),
    .q_valid(qv), .q_ready(rdy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    strobe = 0; wv = 0; breq = 0; busy = 0; tes = 0; trd = 0; tclr = 0; deset = 0;
    id = 0; md = 0; sz = 0; rdy = '0;
  endtask

  function automatic int qvec();
    int v = 0;
    for (int i = 0; i < NCH; i++) if (mcnt[i] > 0) v |= (1 << i);
    return v;
  endfunction

  // Reference model of one clock edge, written from the requirements.
  task automatic model();
    bit acc = !mfroz, hit0 = 0, frz = 0, push = 0, clr = 0, endc = 0, unf;
    int tgt = 0;
    if (strobe && acc) begin
      if (breq) begin push = 1; tgt = 2; end
      else if (!wv) begin
        if (mlastv) begin
          if (mlast != 0) begin push = 1; tgt = mlast; end
          else if (mte) frz = 1;
          else hit0 = 1;
        end
      end else if (id != 0) begin push = 1; tgt = id; end
      else if (md == 0 && sz != 5 && sz != 6) hit0 = 1;
      else if (md != 0 && sz == 7) endc = 1;
      else if (sz == 6 && md != 2) clr = 1;
      if (push || hit0 && wv) begin mlastv = 1; mlast = push ? tgt : 0; end
    end
    for (int i = 0; i < NCH; i++) begin
      int c = mcnt[i];
      if (clr) c = 0;
      else begin
        if (rdy[i] && mcnt[i] > 0) c--;
        if (push && tgt == i + 1 && mcnt[i] < DEPTH) c++;
      end
      mcnt[i] = c;
    end
    mreq = hit0 && !busy;
    mbav = breq && !strobe;
    unf = tclr && mrd && !tes;
    if (unf) mrd = 0; else if (trd && mte) mrd = 1;
    if (unf) mfroz = 0; else if (frz) mfroz = 1;
    if (tes) mte = 1; else if (unf) mte = 0;
    if (endc) mde = 0; else if (deset) mde = 1;
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk("R1 ch0_req", ch0_req, mreq);
    chk("R2 ch0_de", ch0_de, mde);
    chk("R4 q_valid", qv, qvec());
    chk("R8 frozen", frozen, mfroz);
    chk("R9 bus_avail", bavail, mbav);
    chk("R10 te_flag", te_flag, mte);
    idle();
  endtask

  task automatic word(input int i, input int m, input int s);
    strobe = 1; wv = 1; id = 2'(i); md = 2'(m); sz = 3'(s);
  endtask

  task automatic drain(input int ch, output int n);
    n = 0;
    for (int k = 0; k < DEPTH + 3; k++) begin
      rdy[ch] = 1;
      if (qv[ch]) n++;
      step();
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    idle();
    foreach (mcnt[i]) mcnt[i] = 0;
    mlast = 0; mlastv = 0; mte = 0; mrd = 0; mfroz = 0; mde = 0; mreq = 0; mbav = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ch0_req", ch0_req, 0);
    chk("R4 reset q_valid", qv, 0);
    rst_n = 1;
    // R7: bare strobe before any decoded word is ignored
    strobe = 1; step();
    chk("R7 fresh bare no queue", qv, 0);
    // R4/R5: five pushes to channel 1 with odd fields, four survive
    for (int k = 0; k < 5; k++) begin word(1, k, 7 - k); step(); end
    drain(0, n);
    chk("R5 full queue drops fifth", n, DEPTH);
    // R3: fill channels 2 and 3 then clear
    word(2, 0, 0); step(); word(3, 1, 1); step();
    word(0, 0, 6); step();
    chk("R3 clear empties", qv, 0);
    // R6: channel-0 word while busy
    word(0, 0, 2); busy = 1; step();
    chk("R6 busy drops ch0", ch0_req, 0);
    word(0, 0, 2); step();
    chk("R1 ch0 word", ch0_req, 1);
    // R7: bare strobe repeats channel 3
    word(3, 2, 2); step(); strobe = 1; step();
    drain(2, n);
    chk("R7 bare repeats ch3", n, 2);
    // R2: enable set then end command together with set
    deset = 1; step(); chk("R2 de set", ch0_de, 1);
    word(0, 1, 7); deset = 1; step(); chk("R2 end wins", ch0_de, 0);
    // R8: freeze and release
    word(0, 0, 0); step(); tes = 1; step();
    strobe = 1; step(); chk("R8 frozen", frozen, 1);
    word(1, 0, 0); step(); chk("R8 frozen ignores push", qv, 0);
    tclr = 1; step(); chk("R8 clear w/o read", frozen, 1);
    trd = 1; step(); tclr = 1; step();
    chk("R8 released", frozen, 0); chk("R10 te cleared", te_flag, 0);
    // R9: direct request on channel 2
    strobe = 1; breq = 1; step();
    chk("R9 no bus_avail", bavail, 0); chk("R9 ch2 queued", qv, 2);
    breq = 1; step(); chk("R9 bus_avail follows", bavail, 1);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom % 100;
      strobe = (r < 45); wv = ($urandom % 4) != 0; breq = ($urandom % 10) == 0;
      id = 2'($urandom % 4); md = 2'($urandom % 4); sz = 3'($urandom % 8);
      busy = ($urandom % 4) == 0; tes = ($urandom % 40) == 0;
      trd = ($urandom % 6) == 0; tclr = ($urandom % 6) == 0;
      deset = ($urandom % 5) == 0; rdy = 3'($urandom % 8);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule